// File: doc/BRIEF.md
# MMU Fill Register Front End

This block is the register-side front end of a translation buffer. Software reaches it through memory-mapped register accesses. Each access carries an 8-bit space code and an offset. The block keeps two tag registers, one for the instruction side and one for the data side, plus a partition register. When a translation misses, the hardware loads the matching tag register with the faulting virtual page and the context.

Loading an entry takes two steps. First the tag register of the chosen side holds the page and context, because software wrote it or because a miss filled it. Then a write to one of that side's fill ports supplies the entry data word. The write offset carries the control bits. The block combines the tag, the partition and those bits into a single insert command for the translation array, which sits outside this block. Every request gets a response exactly one cycle later.

Top module: `mmu_fill_regs`

## Requirements
- R1: After synchronous reset, both tag registers and the partition register read as zero, and neither `rsp_valid` nor `ins_valid` is asserted.
- R2: A `miss_valid` cycle loads the tag register of the side given by `miss_side` (0 = instruction, 1 = data) with `{miss_vaddr[63:13], miss_ctx[12:0]}`.
- R3: Register map. Space 0x10 at offset 0x030 reaches the instruction tag. Space 0x11 at offset 0x030 reaches the data tag. Space 0x11 at offset 0x080 reaches the partition register, which stores `wdata[7:0]` and reads back zero-extended. Read data appears on `rsp_rdata` one cycle after the request.
- R4: If a software tag write and a miss hit the same tag register in the same cycle, the software value is kept.
- R5: A write to an explicit-slot port (space 0x13 for instruction, 0x15 for data) issues an insert with `ins_auto`=0 and `ins_index` = offset[8:3].
- R6: A write to an automatic-replacement port (space 0x12 for instruction, 0x14 for data) issues an insert with `ins_auto`=1 and `ins_index`=0, but only when the offset has no set bits outside [10:9]. Otherwise the write is an error and issues no insert.
- R7: On both fill ports, offset bit 9 becomes `ins_real` and offset bit 10 becomes `ins_fmt`.
- R8: An insert carries the following values from the cycle of the write:
  - `ins_vpage` and `ins_ctx` from bits [63:13] and [12:0] of the side's tag register;
  - `ins_part` from the partition register;
  - `ins_side` from the space code;
  - `ins_data` from the write data.
- R9: Each accepted fill write raises `ins_valid` for exactly the one cycle after the write. No other request raises it.
- R10: A request is an error and changes no state when it is any of the following:
  - an unlisted space;
  - an unlisted offset within spaces 0x10 or 0x11 (including offset 0x080 in space 0x10);
  - a read of a fill port.

  An error request gives `rsp_err`=1 and `rsp_rdata`=0.
- R11: Every request produces exactly one `rsp_valid` pulse in the following cycle. Writes return `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 8 | Space code |
| req_offset | input | 12 | Offset within the space |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response, one cycle after request |
| rsp_err | output | 1 | Request was unsupported |
| rsp_rdata | output | 64 | Read data |
| miss_valid | input | 1 | Translation miss capture strobe |
| miss_side | input | 1 | 0 = instruction, 1 = data |
| miss_vaddr | input | 64 | Faulting virtual address |
| miss_ctx | input | 13 | Faulting context |
| ins_valid | output | 1 | Insert command pulse |
| ins_side | output | 1 | Target array side |
| ins_vpage | output | 51 | Virtual page |
| ins_ctx | output | 13 | Context |
| ins_part | output | 8 | Partition |
| ins_real | output | 1 | Real-address entry flag |
| ins_fmt | output | 1 | Entry data format select |
| ins_auto | output | 1 | 1 = array picks the slot |
| ins_index | output | 6 | Explicit slot index |
| ins_data | output | 64 | Entry data word |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle response cadence;
- the one-cycle insert pulse after each fill;
- the absence of an insert alongside an error;
- the capture of miss and software values into the tag registers;
- the copy of the real and format bits.

Scenario checks are needed for the rest:
- whether the decoder accepts the right space and offset pairs;
- that an insert uses the tag as it stood before a simultaneous miss;
- that the partition register zero-extends on readback;
- that error requests leave every register untouched.

The random stream mixes misses into register traffic so that these orderings come up often.

// File: rtl/mmu_fill_pkg.sv
package mmu_fill_pkg;
  typedef enum logic {SIDE_I = 1'b0, SIDE_D = 1'b1} side_e;

  localparam logic [7:0] SPACE_IREG  = 8'h10;
  localparam logic [7:0] SPACE_DREG  = 8'h11;
  localparam logic [7:0] SPACE_IAUTO = 8'h12;
  localparam logic [7:0] SPACE_ISLOT = 8'h13;
  localparam logic [7:0] SPACE_DAUTO = 8'h14;
  localparam logic [7:0] SPACE_DSLOT = 8'h15;

  localparam int OFS_TAG   = 48;   // 0x030
  localparam int OFS_PART  = 128;  // 0x080
  localparam int REAL_BIT  = 9;
  localparam int FMT_BIT   = 10;
  localparam int IDX_LSB   = 3;
endpackage

// File: rtl/mmu_req_decode.sv
module mmu_req_decode
  import mmu_fill_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             valid,
  input  logic             write,
  input  logic [7:0]       space,
  input  logic [OFS_W-1:0] offset,
  output logic             sel_tag_i,
  output logic             sel_tag_d,
  output logic             sel_part,
  output logic             fill,
  output logic             fill_side,
  output logic             fill_expl,
  output logic             bad
);
  localparam logic [OFS_W-1:0] AUTO_OK = OFS_W'((1 << REAL_BIT) | (1 << FMT_BIT));
  localparam logic [OFS_W-1:0] O_TAG   = OFS_W'(OFS_TAG);
  localparam logic [OFS_W-1:0] O_PART  = OFS_W'(OFS_PART);

  always_comb begin
    sel_tag_i = 1'b0;
    sel_tag_d = 1'b0;
    sel_part  = 1'b0;
    fill      = 1'b0;
    fill_side = 1'b0;
    fill_expl = 1'b0;
    bad       = 1'b0;
    if (valid) begin
      case (space)
        SPACE_IREG: begin
          if (offset == O_TAG) sel_tag_i = 1'b1;
          else                 bad = 1'b1;
        end
        SPACE_DREG: begin
          if (offset == O_TAG)       sel_tag_d = 1'b1;
          else if (offset == O_PART) sel_part  = 1'b1;
          else                       bad = 1'b1;
        end
        SPACE_IAUTO, SPACE_DAUTO: begin
          fill_side = (space == SPACE_DAUTO);
          if (write && ((offset & ~AUTO_OK) == '0)) fill = 1'b1;
          else                                       bad  = 1'b1;
        end
        SPACE_ISLOT, SPACE_DSLOT: begin
          fill_side = (space == SPACE_DSLOT);
          fill_expl = 1'b1;
          if (write) fill = 1'b1;
          else       bad  = 1'b1;
        end
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mmu_tag_reg.sv
module mmu_tag_reg #(
  parameter int VA_W  = 64,
  parameter int CTX_W = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sw_we,
  input  logic [VA_W-1:0]       sw_data,
  input  logic                  miss_we,
  input  logic [VA_W-CTX_W-1:0] miss_page,
  input  logic [CTX_W-1:0]      miss_ctx,
  output logic [VA_W-1:0]       q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (sw_we)   q <= sw_data;
    else if (miss_we) q <= {miss_page, miss_ctx};
  end

  p_miss_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (miss_we && !sw_we) |=> (q == {$past(miss_page), $past(miss_ctx)}));

  p_sw_wins_r4: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (q == $past(sw_data)));
endmodule

// File: rtl/mmu_insert_gen.sv
module mmu_insert_gen #(
  parameter int VA_W   = 64,
  parameter int CTX_W  = 13,
  parameter int PART_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fill,
  input  logic                  fill_side,
  input  logic                  fill_expl,
  input  logic                  real_bit,
  input  logic                  fmt_bit,
  input  logic [IDX_W-1:0]      slot,
  input  logic [VA_W-1:0]       wdata,
  input  logic [VA_W-1:0]       tag_i,
  input  logic [VA_W-1:0]       tag_d,
  input  logic [PART_W-1:0]     part,
  output logic                  ins_valid,
  output logic                  ins_side,
  output logic [VA_W-CTX_W-1:0] ins_vpage,
  output logic [CTX_W-1:0]      ins_ctx,
  output logic [PART_W-1:0]     ins_part,
  output logic                  ins_real,
  output logic                  ins_fmt,
  output logic                  ins_auto,
  output logic [IDX_W-1:0]      ins_index,
  output logic [VA_W-1:0]       ins_data
);
  logic [VA_W-1:0] tag_sel;
  assign tag_sel = fill_side ? tag_d : tag_i;

  always_ff @(posedge clk) begin
    if (rst) ins_valid <= 1'b0;
    else     ins_valid <= fill;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      ins_side  <= fill_side;
      ins_vpage <= tag_sel[VA_W-1:CTX_W];
      ins_ctx   <= tag_sel[CTX_W-1:0];
      ins_part  <= part;
      ins_real  <= real_bit;
      ins_fmt   <= fmt_bit;
      ins_auto  <= !fill_expl;
      ins_index <= fill_expl ? slot : '0;
      ins_data  <= wdata;
    end
  end

  p_ins_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    fill |=> ins_valid);

  p_ins_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !fill |=> !ins_valid);

  p_ctl_bits_r7: assert property (@(posedge clk) disable iff (rst)
    fill |=> (ins_real == $past(real_bit)) && (ins_fmt == $past(fmt_bit)));
endmodule

// File: rtl/mmu_fill_regs.sv
module mmu_fill_regs
  import mmu_fill_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int CTX_W  = 13,
  parameter int PART_W = 8,
  parameter int IDX_W  = 6,
  parameter int OFS_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [7:0]            req_space,
  input  logic [OFS_W-1:0]      req_offset,
  input  logic [VA_W-1:0]       req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [VA_W-1:0]       rsp_rdata,
  input  logic                  miss_valid,
  input  logic                  miss_side,
  input  logic [VA_W-1:0]       miss_vaddr,
  input  logic [CTX_W-1:0]      miss_ctx,
  output logic                  ins_valid,
  output logic                  ins_side,
  output logic [VA_W-CTX_W-1:0] ins_vpage,
  output logic [CTX_W-1:0]      ins_ctx,
  output logic [PART_W-1:0]     ins_part,
  output logic                  ins_real,
  output logic                  ins_fmt,
  output logic                  ins_auto,
  output logic [IDX_W-1:0]      ins_index,
  output logic [VA_W-1:0]       ins_data
);
  localparam int NSIDE = 2;

  logic sel_tag_i, sel_tag_d, sel_part, fill, fill_side, fill_expl, bad;

  mmu_req_decode #(.OFS_W(OFS_W)) u_dec (
    .valid     (req_valid),
    .write     (req_write),
    .space     (req_space),
    .offset    (req_offset),
    .sel_tag_i (sel_tag_i),
    .sel_tag_d (sel_tag_d),
    .sel_part  (sel_part),
    .fill      (fill),
    .fill_side (fill_side),
    .fill_expl (fill_expl),
    .bad       (bad)
  );

  logic [VA_W-1:0]  tag_q [NSIDE];
  logic [NSIDE-1:0] sw_we_v, miss_we_v;
  assign sw_we_v   = {sel_tag_d & req_write, sel_tag_i & req_write};
  assign miss_we_v = {miss_valid & miss_side, miss_valid & ~miss_side};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    mmu_tag_reg #(.VA_W(VA_W), .CTX_W(CTX_W)) u_tag (
      .clk       (clk),
      .rst       (rst),
      .sw_we     (sw_we_v[s]),
      .sw_data   (req_wdata),
      .miss_we   (miss_we_v[s]),
      .miss_page (miss_vaddr[VA_W-1:CTX_W]),
      .miss_ctx  (miss_ctx),
      .q         (tag_q[s])
    );
  end

  logic [PART_W-1:0] part_q;
  always_ff @(posedge clk) begin
    if (rst)                        part_q <= '0;
    else if (sel_part && req_write) part_q <= req_wdata[PART_W-1:0];
  end

  logic [VA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      if (sel_tag_i)      rd_mux = tag_q[0];
      else if (sel_tag_d) rd_mux = tag_q[1];
      else if (sel_part)  rd_mux = VA_W'(part_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= bad;
      rsp_rdata <= rd_mux;
    end
  end

  mmu_insert_gen #(.VA_W(VA_W), .CTX_W(CTX_W), .PART_W(PART_W), .IDX_W(IDX_W)) u_ins (
    .clk       (clk),
    .rst       (rst),
    .fill      (fill),
    .fill_side (fill_side),
    .fill_expl (fill_expl),
    .real_bit  (req_offset[REAL_BIT]),
    .fmt_bit   (req_offset[FMT_BIT]),
    .slot      (req_offset[IDX_LSB+IDX_W-1:IDX_LSB]),
    .wdata     (req_wdata),
    .tag_i     (tag_q[0]),
    .tag_d     (tag_q[1]),
    .part      (part_q),
    .ins_valid (ins_valid),
    .ins_side  (ins_side),
    .ins_vpage (ins_vpage),
    .ins_ctx   (ins_ctx),
    .ins_part  (ins_part),
    .ins_real  (ins_real),
    .ins_fmt   (ins_fmt),
    .ins_auto  (ins_auto),
    .ins_index (ins_index),
    .ins_data  (ins_data)
  );

  p_rsp_follow_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_rsp_only_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_err_no_ins_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> !ins_valid);

  p_err_part_r10: assert property (@(posedge clk) disable iff (rst)
    bad |=> $stable(part_q));

  p_ins_from_write_r9: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> (rsp_valid && !rsp_err));
endmodule

// File: tb/sim_mmu_fill_regs.sv
`timescale 1ns/1ps
module sim_mmu_fill_regs;
  localparam logic [7:0] S_IREG = 8'h10, S_DREG = 8'h11, S_IAUTO = 8'h12,
                         S_ISLOT = 8'h13, S_DAUTO = 8'h14, S_DSLOT = 8'h15;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write;
  logic [7:0] req_space;
  logic [11:0] req_offset;
  logic [63:0] req_wdata;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic miss_valid, miss_side;
  logic [63:0] miss_vaddr;
  logic [12:0] miss_ctx;
  logic ins_valid, ins_side, ins_real, ins_fmt, ins_auto;
  logic [50:0] ins_vpage;
  logic [12:0] ins_ctx;
  logic [7:0] ins_part;
  logic [5:0] ins_index;
  logic [63:0] ins_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [63:0] m_tag [2];
  logic [7:0]  m_part;

  always #5 clk = ~clk;

  mmu_fill_regs u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic rv, input logic w, input logic [7:0] sp,
                    input logic [11:0] of, input logic [63:0] wd,
                    input logic mv, input logic ms, input logic [63:0] mva,
                    input logic [12:0] mc);
    logic bad, fill, fside, expl;
    int tgt;
    logic [63:0] rd, t;
    bad = 0; fill = 0; fside = 0; expl = 0; tgt = 3; rd = '0;
    if (rv) begin
      case (sp)
        S_IREG: if (of == 12'h030) tgt = 0; else bad = 1;
        S_DREG: if (of == 12'h030) tgt = 1; else if (of == 12'h080) tgt = 2; else bad = 1;
        S_IAUTO, S_DAUTO: begin
          fside = (sp == S_DAUTO);
          if (w && ((of & ~12'h600) == 0)) fill = 1; else bad = 1;
        end
        S_ISLOT, S_DSLOT: begin
          fside = (sp == S_DSLOT); expl = 1;
          if (w) fill = 1; else bad = 1;
        end
        default: bad = 1;
      endcase
    end
    if (!w) begin
      if (tgt == 0) rd = m_tag[0];
      else if (tgt == 1) rd = m_tag[1];
      else if (tgt == 2) rd = {56'd0, m_part};
    end
    @(negedge clk);
    req_valid = rv; req_write = w; req_space = sp; req_offset = of; req_wdata = wd;
    miss_valid = mv; miss_side = ms; miss_vaddr = mva; miss_ctx = mc;
    @(negedge clk);
    req_valid = 0; miss_valid = 0;
    chk("R11 rsp_valid", 64'(rsp_valid), 64'(rv));
    if (rv) begin
      chk("R10 rsp_err", 64'(rsp_err), 64'(bad));
      chk("R3 rsp_rdata", rsp_rdata, rd);
    end
    chk("R9 ins_valid", 64'(ins_valid), 64'(fill));
    if (fill) begin
      t = m_tag[fside];
      chk("R8 ins_side", 64'(ins_side), 64'(fside));
      chk("R8 ins_vpage", 64'(ins_vpage), 64'(t[63:13]));
      chk("R8 ins_ctx", 64'(ins_ctx), 64'(t[12:0]));
      chk("R8 ins_part", 64'(ins_part), 64'(m_part));
      chk("R8 ins_data", ins_data, wd);
      chk("R7 ins_real", 64'(ins_real), 64'(of[9]));
      chk("R7 ins_fmt", 64'(ins_fmt), 64'(of[10]));
      chk("R5 R6 ins_auto", 64'(ins_auto), 64'(!expl));
      chk("R5 R6 ins_index", 64'(ins_index), expl ? 64'(of[8:3]) : 64'd0);
    end
    if (mv) m_tag[ms] = {mva[63:13], mc};           // R2
    if (w && tgt < 2) m_tag[tgt] = wd;               // R4: software wins
    if (w && tgt == 2) m_part = wd[7:0];
  endtask

  task automatic rd_all(input string req);
    op(1, 0, S_IREG, 12'h030, 0, 0, 0, 0, 0);
    op(1, 0, S_DREG, 12'h030, 0, 0, 0, 0, 0);
    op(1, 0, S_DREG, 12'h080, 0, 0, 0, 0, 0);
    checks++;
    if (req.len() == 0) errors++;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    req_valid = 0; req_write = 0; req_space = 0; req_offset = 0; req_wdata = 0;
    miss_valid = 0; miss_side = 0; miss_vaddr = 0; miss_ctx = 0;
    m_tag[0] = 0; m_tag[1] = 0; m_part = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 0);
    chk("R1 ins_valid in reset", 64'(ins_valid), 0);
    rst = 0;
    rd_all("R1");
    // R2 miss capture on each side
    op(0, 0, 0, 0, 0, 1, 0, 64'hDEAD_BEEF_CAFE_F123, 13'h1ABC);
    op(0, 0, 0, 0, 0, 1, 1, 64'h1234_5678_9ABC_DFFF, 13'h0055);
    rd_all("R2");
    // R3 partition zero-extension
    op(1, 1, S_DREG, 12'h080, 64'hFFFF_FFFF_FFFF_F1A5, 0, 0, 0, 0);
    rd_all("R3");
    // R4 software write and miss to the same tag
    op(1, 1, S_DREG, 12'h030, 64'h0BAD_F00D_0000_1111, 1, 1, 64'hFFFF_0000_FFFF_0000, 13'h1FFF);
    rd_all("R4");
    // R5 explicit slot 63, R7 both control bits
    op(1, 1, S_ISLOT, 12'h7F8, 64'hA5A5_5A5A_0F0F_F0F0, 0, 0, 0, 0);
    // R8 insert uses tag before a simultaneous miss
    op(1, 1, S_DAUTO, 12'h200, 64'h1111_2222_3333_4444, 1, 1, 64'h7777_8888_9999_AAAA, 13'h0777);
    // R6 stray offset bit makes an error
    op(1, 1, S_IAUTO, 12'h410, 64'h5, 0, 0, 0, 0);
    // R10 fill-port read, offset 0x080 on instruction space, unknown space
    op(1, 0, S_DSLOT, 12'h008, 0, 0, 0, 0, 0);
    op(1, 1, S_IREG, 12'h080, 64'h99, 0, 0, 0, 0);
    op(1, 1, 8'h77, 12'h030, 64'h1, 0, 0, 0, 0);
    rd_all("R10");
    // R9 back-to-back fills then idle
    op(1, 1, S_DSLOT, 12'h018, 64'h1, 0, 0, 0, 0);
    op(1, 1, S_IAUTO, 12'h600, 64'h2, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] sp;
      logic [11:0] of;
      int k;
      k = $urandom_range(0, 7);
      case (k)
        0: sp = S_IREG; 1: sp = S_DREG; 2: sp = S_IAUTO; 3: sp = S_ISLOT;
        4: sp = S_DAUTO; 5: sp = S_DSLOT; 6: sp = S_DREG; default: sp = 8'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: of = 12'h030;
        1: of = 12'h080;
        2: of = 12'($urandom_range(0, 3) << 9);
        default: of = 12'($urandom);
      endcase
      op(1'($urandom_range(0, 5) != 0), 1'($urandom), sp, of,
         {$urandom, $urandom}, 1'($urandom_range(0, 2) == 0), 1'($urandom),
         {$urandom, $urandom}, 13'($urandom));
    end
    rd_all("R2 R3");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule